// File: doc/BRIEF.md
# Linked-Descriptor Memory-to-Stream DMA

This block walks a linked list of transfer descriptors held in word-addressed memory and streams the words each one points at out through a 32-bit valid/ready interface with packet boundary flags. One read/write memory port serves both descriptor traffic and payload reads. The memory answers a read one cycle after it is issued. A typical use is feeding a display pipeline from a frame buffer. The frame is larger than one descriptor can carry, so it is split across several chained descriptors. Only the first of them marks the packet start and only the last marks the packet end.

Software writes the word address of the first descriptor into a pointer register and sets a start bit. The block fetches each descriptor and streams its payload. It then writes the descriptor back with its ownership flag cleared and follows the next pointer. The chain ends at the first descriptor whose ownership flag is already clear. Once every beat has been accepted downstream, the block reports completion in a status register and can raise an interrupt. To reuse a chain, software sets the ownership flags again and restarts it.

Top module: `dmac_m2s`

## Requirements
- R1: After reset, st_valid, irq, mem_rd and mem_wr are low, and the status register (CSR address 1) reads 0.
- R2: A descriptor at word address D is three words. D+0 holds the source word address and D+1 holds the next-descriptor word address. D+2 is the control word: bits 15:0 give the byte length, bit 16 is the start flag, bit 17 is the end flag and bit 31 is the ownership flag. An owned descriptor emits ceil(length/4) beats, taken from consecutive words starting at the source address, in address order.
- R3: Descriptors are processed by following next pointers from the head. A descriptor whose bit 31 is clear ends the chain and emits no beats.
- R4: After its payload reads, every owned descriptor has its D+2 word written back with bit 31 cleared and all other bits unchanged. This happens before the next descriptor is fetched.
- R5: st_sop is high only on the first beat of a descriptor whose start flag is set. st_eop is high only on the last beat of a descriptor whose end flag is set.
- R6: While st_valid is high and st_ready is low, st_valid stays high and st_data, st_sop and st_eop hold their values.
- R7: No payload read is issued while the output register holds a beat that is not being accepted in that cycle. mem_rd and mem_wr are never high together.
- R8: Status bit 0 (busy) is high from the start of a chain until it completes. Status bit 1 (done) is set at completion, and completion happens only after the last beat has been accepted.
- R9: irq is high exactly when done is set and both control bits 0 (chain-complete enable) and 1 (global enable) at CSR address 0 are set.
- R10: Writing 1 to status bit 1 clears done and irq. If completion falls in the same cycle as that write, done stays set.
- R11: Writing control bit 2 (start) while busy has no effect, and neither does writing the head pointer (CSR address 2) while busy. The running chain completes unchanged, exactly once.
- R12: A zero-length owned descriptor emits no beats but is still written back.
- R13: After software sets bit 31 again in each descriptor and restarts the block, the chain reproduces the same beat stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_we | input | 1 | CSR write strobe |
| csr_addr | input | 2 | CSR word select: 0 control, 1 status, 2 head pointer |
| csr_wdata | input | 32 | CSR write data |
| csr_rdata | output | 32 | CSR read data (combinational from csr_addr) |
| irq | output | 1 | Chain-complete interrupt |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid the cycle after mem_rd |
| st_valid | output | 1 | Stream beat valid |
| st_ready | input | 1 | Stream sink ready |
| st_data | output | 32 | Stream beat data |
| st_sop | output | 1 | Start-of-packet flag |
| st_eop | output | 1 | End-of-packet flag |

## Verification
Completion sets the done bit in the same cycle that software may be writing 1 to that bit to clear it. The bench provokes this by reading status at every falling edge while busy is high and issuing a clear pulse each time. One of those pulses is therefore certain to land on the completing edge. The first falling edge that sees busy low must then see done still set, and irq high. The output-register stall also interacts with the descriptor walk. The sink's ready is randomized throughout, so write-backs and fetches overlap a held final beat.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
    localparam int DW       = 32;
    localparam int OWN_BIT  = 31;
    localparam int EOP_BIT  = 17;
    localparam int SOP_BIT  = 16;
    localparam int CSR_CTRL = 0;
    localparam int CSR_STAT = 1;
    localparam int CSR_HEAD = 2;

    typedef enum logic [2:0] {
        W_IDLE, W_F0, W_F1, W_F2, W_DEC, W_XFER, W_WB, W_END
    } wstate_e;
endpackage

// File: rtl/dmac_csr.sv
module dmac_csr
    import dmac_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          csr_we,
    input  logic [1:0]    csr_addr,
    input  logic [DW-1:0] csr_wdata,
    output logic [DW-1:0] csr_rdata,
    input  logic          busy,
    input  logic          done_set,
    output logic          start,
    output logic [AW-1:0] head,
    output logic          done_flag,
    output logic          irq
);
    typedef struct packed {
        logic          ie_chain;
        logic          ie_glob;
        logic          done;
        logic [AW-1:0] head;
    } creg_t;

    creg_t q, d;

    always_comb begin
        d     = q;
        start = 1'b0;
        if (csr_we) begin
            case (int'(csr_addr))
                CSR_CTRL: begin
                    d.ie_chain = csr_wdata[0];
                    d.ie_glob  = csr_wdata[1];
                    start      = csr_wdata[2] && !busy;
                end
                CSR_STAT: if (csr_wdata[1]) d.done = 1'b0;
                CSR_HEAD: d.head = csr_wdata[AW-1:0];
                default: ;
            endcase
        end
        // completion beats a simultaneous clear
        if (done_set) d.done = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (int'(csr_addr))
            CSR_CTRL: csr_rdata = {{(DW-2){1'b0}}, q.ie_glob, q.ie_chain};
            CSR_STAT: csr_rdata = {{(DW-2){1'b0}}, q.done, busy};
            CSR_HEAD: csr_rdata = DW'(q.head);
            default:  csr_rdata = '0;
        endcase
    end

    assign head      = q.head;
    assign done_flag = q.done;
    assign irq       = q.done && q.ie_chain && q.ie_glob;
endmodule

// File: rtl/dmac_outbuf.sv
module dmac_outbuf
    import dmac_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld,
    input  logic [DW-1:0] ld_data,
    input  logic          ld_sop,
    input  logic          ld_eop,
    input  logic          ready,
    output logic          valid,
    output logic [DW-1:0] data,
    output logic          sop,
    output logic          eop
);
    typedef struct packed {
        logic          v;
        logic [DW-1:0] dat;
        logic          s;
        logic          e;
    } oreg_t;

    oreg_t q, d;

    always_comb begin
        d = q;
        if (q.v && ready) d.v = 1'b0;
        if (ld) begin
            d.v   = 1'b1;
            d.dat = ld_data;
            d.s   = ld_sop;
            d.e   = ld_eop;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign valid = q.v;
    assign data  = q.dat;
    assign sop   = q.s;
    assign eop   = q.e;
endmodule

// File: rtl/dmac_walker.sv
module dmac_walker
    import dmac_pkg::*;
#(
    parameter int AW    = 32,
    parameter int LEN_W = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] head,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          ob_full,
    input  logic          ob_ready,
    output logic          ld,
    output logic          ld_sop,
    output logic          ld_eop,
    output logic          busy,
    output logic          done_set,
    output logic          data_rd
);
    localparam int CW = LEN_W - 1;

    typedef struct packed {
        wstate_e       st;
        logic [AW-1:0] cur;
        logic [AW-1:0] src;
        logic [AW-1:0] nxt;
        logic [DW-1:0] ctl;
        logic [CW-1:0] left;
        logic          first;
        logic          pend;
        logic          psop;
        logic          peop;
        logic          busy;
    } wreg_t;

    wreg_t q, d;
    logic [LEN_W:0] lsum;

    assign lsum = {1'b0, mem_rdata[LEN_W-1:0]} + (LEN_W+1)'(3);

    always_comb begin
        d         = q;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        done_set  = 1'b0;
        data_rd   = 1'b0;
        ld        = q.pend;
        ld_sop    = q.psop;
        ld_eop    = q.peop;
        if (q.pend) d.pend = 1'b0;
        case (q.st)
            W_IDLE: if (start) begin
                d.cur  = head;
                d.busy = 1'b1;
                d.st   = W_F0;
            end
            W_F0: begin
                mem_rd   = 1'b1;
                mem_addr = q.cur;
                d.st     = W_F1;
            end
            W_F1: begin
                mem_rd   = 1'b1;
                mem_addr = q.cur + AW'(1);
                d.src    = AW'(mem_rdata);
                d.st     = W_F2;
            end
            W_F2: begin
                mem_rd   = 1'b1;
                mem_addr = q.cur + AW'(2);
                d.nxt    = AW'(mem_rdata);
                d.st     = W_DEC;
            end
            W_DEC: begin
                d.ctl = mem_rdata;
                if (!mem_rdata[OWN_BIT]) begin
                    d.st = W_END;
                end else begin
                    d.left  = lsum[LEN_W:2];
                    d.first = 1'b1;
                    d.st    = W_XFER;
                end
            end
            W_XFER: begin
                if (q.left == '0) begin
                    if (!q.pend) d.st = W_WB;
                end else if (!q.pend && (!ob_full || ob_ready)) begin
                    mem_rd   = 1'b1;
                    data_rd  = 1'b1;
                    mem_addr = q.src;
                    d.src    = q.src + AW'(1);
                    d.left   = q.left - CW'(1);
                    d.pend   = 1'b1;
                    d.psop   = q.first && q.ctl[SOP_BIT];
                    d.peop   = (q.left == CW'(1)) && q.ctl[EOP_BIT];
                    d.first  = 1'b0;
                end
            end
            W_WB: begin
                mem_wr    = 1'b1;
                mem_addr  = q.cur + AW'(2);
                mem_wdata = q.ctl & ~(DW'(1) << OWN_BIT);
                d.cur     = q.nxt;
                d.st      = W_F0;
            end
            W_END: if (!ob_full) begin
                d.busy   = 1'b0;
                done_set = 1'b1;
                d.st     = W_IDLE;
            end
            default: d.st = W_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: W_IDLE, default: '0};
        else        q <= d;
    end

    assign busy = q.busy;
endmodule

// File: rtl/dmac_m2s.sv
module dmac_m2s
    import dmac_pkg::*;
#(
    parameter int AW    = 32,
    parameter int LEN_W = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          csr_we,
    input  logic [1:0]    csr_addr,
    input  logic [31:0]   csr_wdata,
    output logic [31:0]   csr_rdata,
    output logic          irq,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    output logic          st_valid,
    input  logic          st_ready,
    output logic [31:0]   st_data,
    output logic          st_sop,
    output logic          st_eop
);
    logic          busy, done_set, start, done_flag, data_rd;
    logic          ld, ld_sop, ld_eop;
    logic [AW-1:0] head;

    dmac_csr #(.AW(AW)) u_csr (
        .clk(clk), .rst_n(rst_n),
        .csr_we(csr_we), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
        .csr_rdata(csr_rdata), .busy(busy), .done_set(done_set),
        .start(start), .head(head), .done_flag(done_flag), .irq(irq)
    );

    dmac_walker #(.AW(AW), .LEN_W(LEN_W)) u_walk (
        .clk(clk), .rst_n(rst_n), .start(start), .head(head),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .ob_full(st_valid), .ob_ready(st_ready),
        .ld(ld), .ld_sop(ld_sop), .ld_eop(ld_eop),
        .busy(busy), .done_set(done_set), .data_rd(data_rd)
    );

    dmac_outbuf u_ob (
        .clk(clk), .rst_n(rst_n), .ld(ld), .ld_data(mem_rdata),
        .ld_sop(ld_sop), .ld_eop(ld_eop), .ready(st_ready),
        .valid(st_valid), .data(st_data), .sop(st_sop), .eop(st_eop)
    );
endmodule

// File: rtl/dmac_m2s_chk.sv
module dmac_m2s_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        st_valid,
    input logic        st_ready,
    input logic [31:0] st_data,
    input logic        st_sop,
    input logic        st_eop,
    input logic        mem_rd,
    input logic        mem_wr,
    input logic [31:0] mem_wdata,
    input logic        data_rd,
    input logic        busy,
    input logic        done_set,
    input logic        done_flag,
    input logic        csr_we,
    input logic [1:0]  csr_addr,
    input logic [31:0] csr_wdata,
    input logic        irq
);
    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && !st_ready) |=> (st_valid && $stable(st_data) && $stable(st_sop) && $stable(st_eop)));

    // R7
    no_rd_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && !st_ready) |-> !data_rd);

    // R7
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R4
    wb_own_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> !mem_wdata[31]);

    // R8
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flag) |-> $past(busy));

    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_set |=> done_flag);

    // R10
    clear_drops_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we && csr_addr == 2'd1 && csr_wdata[1] && !done_set) |=> !irq);
endmodule

bind dmac_m2s dmac_m2s_chk u_chk (
    .clk(clk), .rst_n(rst_n),
    .st_valid(st_valid), .st_ready(st_ready), .st_data(st_data),
    .st_sop(st_sop), .st_eop(st_eop),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
    .data_rd(data_rd), .busy(busy), .done_set(done_set), .done_flag(done_flag),
    .csr_we(csr_we), .csr_addr(csr_addr), .csr_wdata(csr_wdata), .irq(irq)
);

// File: tb/sim_dmac_m2s.sv
module sim_dmac_m2s;
    localparam int CLK_NS = 10;
    localparam int MSZ    = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_we = 1'b0;
    logic [1:0]  csr_addr = 2'd0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic        irq;
    logic        mem_rd, mem_wr;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        st_valid, st_sop, st_eop;
    logic        st_ready = 1'b1;
    logic [31:0] st_data;

    logic        tb_we = 1'b0;
    logic [11:0] tb_addr = '0;
    logic [31:0] tb_wdata = '0;
    logic [31:0] mem [0:MSZ-1];
    logic        written [0:MSZ-1];

    int checks = 0;
    int fails  = 0;
    int ready_pct = 100;
    logic [33:0] exq[$];
    int          dlist[$];
    logic [31:0] clist[$];

    always #(CLK_NS/2) clk = ~clk;

    dmac_m2s u0 (
        .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .irq(irq),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .st_valid(st_valid), .st_ready(st_ready), .st_data(st_data),
        .st_sop(st_sop), .st_eop(st_eop)
    );

    function automatic logic [31:0] pat(int a);
        return (32'(a) * 32'h9E3779B1) ^ 32'hC0DE0000;
    endfunction

    function automatic logic [31:0] peek(int a);
        return written[a] ? mem[a] : pat(a);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MSZ; i++) written[i] <= 1'b0;
        end else begin
            if (tb_we) begin
                mem[tb_addr]     <= tb_wdata;
                written[tb_addr] <= 1'b1;
            end
            if (mem_wr) begin
                mem[mem_addr[11:0]]     <= mem_wdata;
                written[mem_addr[11:0]] <= 1'b1;
            end
            if (mem_rd) mem_rdata <= peek(int'(mem_addr[11:0]));
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // stream sink and scoreboard (R2, R5)
    initial begin
        forever begin
            @(negedge clk);
            st_ready = ($urandom % 100) < ready_pct;
            if (rst_n && st_valid && st_ready) begin
                if (exq.size() == 0) begin
                    chk(1'b0, "R3 unexpected beat", st_data, 32'h0);
                end else begin
                    logic [33:0] e;
                    e = exq.pop_front();
                    chk(st_data == e[31:0], "R2 beat data", st_data, e[31:0]);
                    chk(st_sop == e[33] && st_eop == e[32], "R5 sop/eop",
                        {30'd0, st_sop, st_eop}, {30'd0, e[33], e[32]});
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    task automatic mput(input int a, input logic [31:0] v);
        @(negedge clk);
        tb_we = 1'b1; tb_addr = 12'(a); tb_wdata = v;
        @(negedge clk);
        tb_we = 1'b0;
    endtask

    task automatic csr_wr(input int a, input logic [31:0] v);
        @(negedge clk);
        csr_we = 1'b1; csr_addr = 2'(a); csr_wdata = v;
        @(negedge clk);
        csr_we = 1'b0;
    endtask

    task automatic csr_rd(input int a, output logic [31:0] v);
        @(negedge clk);
        csr_addr = 2'(a);
        #1 v = csr_rdata;
    endtask

    // descriptor builder: pushes expected beats when owned
    task automatic mk_desc(input int da, input int src, input int nxt, input int len,
                           input bit sop, input bit eop, input bit own);
        logic [31:0] ctl;
        int nw;
        ctl = {own, 13'd0, eop, sop, 16'(len)};
        mput(da, 32'(src));
        mput(da + 1, 32'(nxt));
        mput(da + 2, ctl);
        if (own) begin
            nw = (len + 3) / 4;
            for (int i = 0; i < nw; i++)
                exq.push_back({sop && i == 0, eop && i == nw - 1, pat(src + i)});
            dlist.push_back(da);
            clist.push_back(ctl & 32'h7FFF_FFFF);
        end
    endtask

    task automatic start_chain(input int hd, input logic [1:0] en);
        csr_wr(2, 32'(hd));
        csr_wr(0, {29'd0, 1'b1, en});
    endtask

    task automatic wait_idle(input string req);
        logic [31:0] s;
        int n = 0;
        do begin
            csr_rd(1, s);
            n++;
        end while (s[0] && n < 20000);
        chk(!s[0], req, s, 32'h2);
    endtask

    task automatic post_checks(input string tag);
        chk(exq.size() == 0, {tag, " all beats delivered"}, 32'(exq.size()), 32'd0);
        while (dlist.size() > 0) begin
            int da;
            logic [31:0] c;
            da = dlist.pop_front();
            c  = clist.pop_front();
            chk(peek(da + 2) == c, "R4 write-back clears ownership", peek(da + 2), c);
        end
        exq.delete();
    endtask

    initial begin
        logic [31:0] s;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(!st_valid && !irq && !mem_rd && !mem_wr, "R1 outputs idle",
            {28'd0, st_valid, irq, mem_rd, mem_wr}, 32'd0);
        csr_rd(1, s);
        chk(s == 32'd0, "R1 status after reset", s, 32'd0);

        // R2 R3 R5: three descriptors plus terminator, slow sink
        ready_pct = 40;
        mk_desc(12'h800, 100, 12'h804, 40, 1, 0, 1);
        mk_desc(12'h804, 300, 12'h808, 4, 0, 0, 1);
        mk_desc(12'h808, 500, 12'h80C, 22, 0, 1, 1);
        mk_desc(12'h80C, 700, 12'h800, 16, 1, 1, 0);
        start_chain(12'h800, 2'b11);
        csr_rd(1, s);
        chk(s[0] == 1'b1, "R8 busy while running", s, 32'h1);
        wait_idle("R8 busy clears");
        csr_rd(1, s);
        chk(s[1] == 1'b1, "R8 done set", s, 32'h2);
        chk(irq == 1'b1, "R9 irq with both enables", {31'd0, irq}, 32'd1);
        post_checks("R3");

        // R10 clear
        csr_wr(1, 32'h2);
        @(negedge clk);
        chk(irq == 1'b0, "R10 irq cleared", {31'd0, irq}, 32'd0);
        csr_rd(1, s);
        chk(s[1] == 1'b0, "R10 done cleared", s, 32'd0);

        // R13 re-arm, R9 only chain enable
        ready_pct = 100;
        mk_desc(12'h800, 100, 12'h804, 40, 1, 0, 1);
        mk_desc(12'h804, 300, 12'h808, 4, 0, 0, 1);
        mk_desc(12'h808, 500, 12'h80C, 22, 0, 1, 1);
        start_chain(12'h800, 2'b01);
        wait_idle("R13 rerun completes");
        csr_rd(1, s);
        chk(s[1] == 1'b1 && irq == 1'b0, "R9 irq masked by global enable",
            {s[30:0], irq}, 32'h4);
        post_checks("R13");
        csr_wr(1, 32'h2);

        // R11 start and head write while busy
        ready_pct = 50;
        mk_desc(12'h900, 1000, 12'h904, 200, 1, 1, 1);
        mk_desc(12'h904, 0, 0, 0, 0, 0, 0);
        mk_desc(12'hA00, 1500, 12'hA04, 8, 1, 1, 0);
        start_chain(12'h900, 2'b11);
        repeat (10) @(negedge clk);
        csr_wr(2, 32'hA00);
        csr_wr(0, 32'h7);
        wait_idle("R11 chain completes");
        post_checks("R11");
        csr_rd(2, s);
        chk(s == 32'hA00, "R11 head register readback", s, 32'hA00);
        csr_wr(1, 32'h2);

        // R12 zero-length descriptor in the middle
        mk_desc(12'hB00, 200, 12'hB04, 12, 1, 0, 1);
        mk_desc(12'hB04, 400, 12'hB08, 0, 0, 0, 1);
        mk_desc(12'hB08, 600, 12'hB0C, 8, 0, 1, 1);
        mk_desc(12'hB0C, 0, 0, 0, 0, 0, 0);
        start_chain(12'hB00, 2'b11);
        wait_idle("R12 chain completes");
        post_checks("R12");
        csr_wr(1, 32'h2);

        // R3 head not owned: nothing streamed
        mk_desc(12'hC00, 50, 12'hC04, 32, 1, 1, 0);
        start_chain(12'hC00, 2'b11);
        wait_idle("R3 empty chain completes");
        csr_rd(1, s);
        chk(s[1] == 1'b1, "R3 empty chain done", s, 32'h2);
        post_checks("R3 empty");

        // R10 completion coincident with clear: clear every cycle while busy
        mk_desc(12'hC10, 800, 12'hC14, 24, 1, 1, 1);
        mk_desc(12'hC14, 0, 0, 0, 0, 0, 0);
        ready_pct = 70;
        start_chain(12'hC10, 2'b11);
        begin
            int n = 0;
            do begin
                @(negedge clk);
                csr_addr = 2'd1;
                #1 s = csr_rdata;
                if (s[0]) begin
                    csr_we = 1'b1; csr_wdata = 32'h2;
                end else begin
                    csr_we = 1'b0;
                end
                n++;
            end while (s[0] && n < 5000);
            csr_we = 1'b0;
        end
        chk(s[1] == 1'b1, "R10 set wins over clear", s, 32'h2);
        chk(irq == 1'b1, "R10 irq after coincident clear", {31'd0, irq}, 32'd1);
        post_checks("R10");
        csr_wr(1, 32'h2);

        // random chains
        for (int it = 0; it < 8; it++) begin
            int nd;
            int base;
            nd = 1 + int'($urandom % 4);
            base = 12'hD00 + it * 32;
            ready_pct = 20 + int'($urandom % 81);
            for (int k = 0; k < nd; k++)
                mk_desc(base + k * 4, int'($urandom % 1500), base + (k + 1) * 4,
                        int'($urandom % 49), k == 0, k == nd - 1, 1);
            mk_desc(base + nd * 4, 0, 0, 4, 0, 0, 0);
            start_chain(base, 2'b11);
            wait_idle("R2 random chain completes");
            csr_rd(1, s);
            chk(s[1] == 1'b1, "R8 random done", s, 32'h2);
            post_checks("R2 random");
            csr_wr(1, 32'h2);
        end

        repeat (5) @(negedge clk);
        summary();
    end
endmodule